// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block sits in front of a small word-addressed memory that several cores share. Each core has its own request channel. On any cycle the unit accepts at most one request and runs it as an indivisible read-modify-write: the word is read, the new value is computed and written back, and the response is captured, all in the same arbitrated slot. No other access can fall between the read and the write. The operations are plain load and store, exchange, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair. Each core holds one reservation for the store-conditional.

Requests use valid/ready. A core raises `req_valid` and holds its opcode, address and data stable until the cycle in which `req_ready` is high at a rising edge. `req_ready` is high for at most one core per cycle. It is never high while a response is waiting in the output register and `rsp_ready` is low. The response channel also uses valid/ready. A response appears one cycle after acceptance and stays stable until `rsp_ready` is sampled high. Responses come back in the order the requests were accepted, and `rsp_core` names the requester.

Top module: `amo_unit`

## Requirements
- R1: A request accepted at a rising edge gives `rsp_valid`=1 with `rsp_core` equal to the requesting core after that edge. While `rsp_valid`=1 and `rsp_ready`=0, the response holds its value and no request is accepted.
- R2: Competing requests are accepted one per cycle in round-robin order. The search starts at the core after the last one served, so when all cores request after core 0 was served, the order is 1, 2, 3, 0.
- R3: Opcode 0 (load) returns the word without writing it. Opcode 1 (store) writes the request data and returns 0. Opcode 7 behaves as a load.
- R4: Opcode 2 (exchange) writes the request data and returns the previous word.
- R5: Opcode 3 (test-and-set) returns the previous word. It writes 1 only when that word was 0, and otherwise leaves the word unchanged.
- R6: Opcode 4 (fetch-and-increment) returns the previous word and stores it plus one, wrapping from all-ones to zero.
- R7: Opcode 5 (load-linked) returns the word and sets the core's single reservation to that address. A newer load-linked replaces the older reservation.
- R8: Opcode 6 (store-conditional) with a live reservation on the same address writes the request data and returns 1.
- R9: A store-conditional with no reservation, or with a reservation on another address, returns 0 and does not write. Every store-conditional clears its core's reservation.
- R10: Any write to an address clears every reservation on that address, whichever core or opcode made the write. A test-and-set that does not write leaves reservations intact.
- R11: Reset clears all memory words to 0, clears every reservation, clears `rsp_valid`, and holds every `req_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | NUM_CORES | Per-core request valid |
| req_ready | output | NUM_CORES | Per-core request accepted this cycle |
| req_op | input | NUM_CORES*3 | Per-core opcode, core c in bits [3c+2:3c] |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address |
| req_wdata | input | NUM_CORES*DATA_W | Per-core write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_core | output | CORE_W | Core that issued the request being answered |
| rsp_data | output | DATA_W | Previous word, loaded word, 0 for store, or the store-conditional flag |

## Verification
The bench targets the ways reservations can go stale: a store-conditional issued right after a successful one, a store-conditional to an address other than the reserved one, a reservation that a newer load-linked has replaced, and a plain store from another core to a reserved word. A design that failed to clear any of these would report success and corrupt the word. A test-and-set on a word that is already set must leave a reservation alive, and a design that treated it as a write would fail the later store-conditional. Fetch-and-increment is driven through its wrap from all-ones. The bench checks the round-robin order across all four cores, and a design with a fixed-priority arbiter would answer 0 first. Under back-pressure, a design that kept granting would overwrite the response being held.

// File: rtl/amo_pkg.sv
package amo_pkg;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } amo_op_e;

  localparam int unsigned OP_W = 3;

endpackage

// File: rtl/amo_rr_arbiter.sv
module amo_rr_arbiter #(
  parameter int unsigned N      = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             en,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx
);

  logic [IDX_W-1:0] last_q;

  always_comb begin
    logic             found;
    logic [IDX_W-1:0] cand;
    found     = 1'b0;
    grant     = '0;
    grant_idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      cand = IDX_W'((int'(last_q) + 1 + i) % int'(N));
      if (!found && en && req[cand]) begin
        grant[cand] = 1'b1;
        grant_idx   = cand;
        found       = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= IDX_W'(N - 1);
    end else if (|grant) begin
      last_q <= grant_idx;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0); // R2
  AST_NO_GRANT_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> grant == '0); // R1

endmodule

// File: rtl/amo_resv_table.sv
module amo_resv_table #(
  parameter int unsigned N      = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IDX_W-1:0]  core_idx,
  input  logic              is_ll,
  input  logic              is_sc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_wr,
  output logic              sc_ok
);

  logic [N-1:0]      vld_q;
  logic [ADDR_W-1:0] addr_q [N];

  for (genvar c = 0; c < int'(N); c++) begin : g_slot
    logic own;
    logic hit;
    assign own = fire && (core_idx == IDX_W'(c));
    assign hit = vld_q[c] && (addr_q[c] == addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[c]  <= 1'b0;
        addr_q[c] <= '0;
      end else if (own && is_ll) begin
        vld_q[c]  <= 1'b1;
        addr_q[c] <= addr;
      end else if (own && is_sc) begin
        vld_q[c]  <= 1'b0;
      end else if (fire && mem_wr && hit) begin
        vld_q[c]  <= 1'b0;
      end
    end

    AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      (own && is_sc) |=> !vld_q[c]); // R9
    AST_WRITE_KILLS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mem_wr && hit && !(own && is_ll)) |=> !vld_q[c]); // R10
  end

  assign sc_ok = vld_q[core_idx] && (addr_q[core_idx] == addr);

endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  amo_op_e           op,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sc_ok,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] rsp_val
);

  always_comb begin
    wr_en   = 1'b0;
    wr_val  = wdata;
    rsp_val = old_val;
    unique case (op)
      OP_STORE: begin
        wr_en   = 1'b1;
        rsp_val = '0;
      end
      OP_SWAP: wr_en = 1'b1;
      OP_TAS: begin
        wr_en  = (old_val == '0);
        wr_val = DATA_W'(1);
      end
      OP_FINC: begin
        wr_en  = 1'b1;
        wr_val = old_val + DATA_W'(1);
      end
      OP_SC: begin
        wr_en   = sc_ok;
        rsp_val = DATA_W'(sc_ok);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/amo_word_store.sv
module amo_word_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wr_data;
    end
  end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CORES-1:0]          req_valid,
  output logic [NUM_CORES-1:0]          req_ready,
  input  logic [NUM_CORES*OP_W-1:0]     req_op,
  input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
  input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [CORE_W-1:0]             rsp_core,
  output logic [DATA_W-1:0]             rsp_data
);

  logic [OP_W-1:0]   op_a   [NUM_CORES];
  logic [ADDR_W-1:0] addr_a [NUM_CORES];
  logic [DATA_W-1:0] wd_a   [NUM_CORES];

  for (genvar c = 0; c < int'(NUM_CORES); c++) begin : g_unpack
    assign op_a[c]   = req_op[c*OP_W +: OP_W];
    assign addr_a[c] = req_addr[c*ADDR_W +: ADDR_W];
    assign wd_a[c]   = req_wdata[c*DATA_W +: DATA_W];
  end

  logic              can_issue;
  logic [NUM_CORES-1:0] grant;
  logic [CORE_W-1:0] grant_idx;
  logic              fire;
  amo_op_e           sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic [DATA_W-1:0] mem_rd;
  logic              mem_wr;
  logic [DATA_W-1:0] mem_wd;
  logic [DATA_W-1:0] alu_rsp;
  logic              sc_ok;

  assign can_issue = rst_n && (!rsp_valid || rsp_ready);

  amo_rr_arbiter #(.N(NUM_CORES)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_valid),
    .en        (can_issue),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  assign req_ready = grant;
  assign fire      = |grant;
  assign sel_op    = amo_op_e'(op_a[grant_idx]);
  assign sel_addr  = addr_a[grant_idx];
  assign sel_wdata = wd_a[grant_idx];

  amo_resv_table #(.N(NUM_CORES), .ADDR_W(ADDR_W)) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .core_idx (grant_idx),
    .is_ll    (sel_op == OP_LL),
    .is_sc    (sel_op == OP_SC),
    .addr     (sel_addr),
    .mem_wr   (mem_wr),
    .sc_ok    (sc_ok)
  );

  logic alu_wr;

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (sel_op),
    .old_val (mem_rd),
    .wdata   (sel_wdata),
    .sc_ok   (sc_ok),
    .wr_en   (alu_wr),
    .wr_val  (mem_wd),
    .rsp_val (alu_rsp)
  );

  assign mem_wr = fire && alu_wr;

  amo_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (sel_addr),
    .rd_data (mem_rd),
    .wr_en   (mem_wr),
    .wr_data (mem_wd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_data  <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_core  <= grant_idx;
      rsp_data  <= alu_rsp;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_core))); // R1
  AST_RMW_SEES_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && $past(mem_wr) && sel_addr == $past(sel_addr)) |-> mem_rd == $past(mem_wd)); // R4

endmodule

// File: tb/amo_unit_tb.sv
module amo_unit_tb;

  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NV = 37;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [NC-1:0]     req_ready;
  logic [NC*3-1:0]   req_op = '0;
  logic [NC*AW-1:0]  req_addr = '0;
  logic [NC*DW-1:0]  req_wdata = '0;
  logic              rsp_valid;
  logic              rsp_ready = 1'b1;
  logic [1:0]        rsp_core;
  logic [DW-1:0]     rsp_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  amo_unit #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_core(rsp_core),
    .rsp_data(rsp_data)
  );

  // {core, op, addr, wdata, expected response, requirement number}
  localparam logic [76:0] VEC [NV] = '{
    {2'd0, 3'd1, 4'd3,  32'h55,       32'h0,        4'd3},  // R3 store
    {2'd1, 3'd0, 4'd3,  32'h0,        32'h55,       4'd3},  // R3 load
    {2'd2, 3'd2, 4'd3,  32'hAA,       32'h55,       4'd4},  // R4 exchange
    {2'd0, 3'd0, 4'd3,  32'h0,        32'hAA,       4'd4},  // R4
    {2'd1, 3'd3, 4'd5,  32'h0,        32'h0,        4'd5},  // R5 set
    {2'd2, 3'd3, 4'd5,  32'h0,        32'h1,        4'd5},  // R5 already set
    {2'd0, 3'd0, 4'd5,  32'h0,        32'h1,        4'd5},  // R5
    {2'd3, 3'd4, 4'd7,  32'h0,        32'h0,        4'd6},  // R6
    {2'd3, 3'd4, 4'd7,  32'h0,        32'h1,        4'd6},  // R6
    {2'd0, 3'd0, 4'd7,  32'h0,        32'h2,        4'd6},  // R6
    {2'd0, 3'd1, 4'd9,  32'hFFFFFFFF, 32'h0,        4'd3},  // R3
    {2'd1, 3'd4, 4'd9,  32'h0,        32'hFFFFFFFF, 4'd6},  // R6 wrap
    {2'd1, 3'd0, 4'd9,  32'h0,        32'h0,        4'd6},  // R6
    {2'd2, 3'd5, 4'd3,  32'h0,        32'hAA,       4'd7},  // R7
    {2'd2, 3'd6, 4'd3,  32'h77,       32'h1,        4'd8},  // R8
    {2'd0, 3'd0, 4'd3,  32'h0,        32'h77,       4'd8},  // R8
    {2'd2, 3'd6, 4'd3,  32'h11,       32'h0,        4'd9},  // R9 reservation used
    {2'd0, 3'd0, 4'd3,  32'h0,        32'h77,       4'd9},  // R9 no write
    {2'd1, 3'd5, 4'd4,  32'h0,        32'h0,        4'd7},  // R7
    {2'd1, 3'd6, 4'd6,  32'h5,        32'h0,        4'd9},  // R9 other address
    {2'd0, 3'd0, 4'd6,  32'h0,        32'h0,        4'd9},  // R9
    {2'd3, 3'd5, 4'd8,  32'h0,        32'h0,        4'd7},  // R7
    {2'd0, 3'd5, 4'd8,  32'h0,        32'h0,        4'd7},  // R7
    {2'd1, 3'd1, 4'd8,  32'h9,        32'h0,        4'd3},  // R3 store kills
    {2'd3, 3'd6, 4'd8,  32'h3,        32'h0,        4'd10}, // R10
    {2'd0, 3'd6, 4'd8,  32'h4,        32'h0,        4'd10}, // R10
    {2'd0, 3'd0, 4'd8,  32'h0,        32'h9,        4'd10}, // R10
    {2'd3, 3'd5, 4'd10, 32'h0,        32'h0,        4'd7},  // R7
    {2'd3, 3'd5, 4'd11, 32'h0,        32'h0,        4'd7},  // R7 replace
    {2'd3, 3'd6, 4'd10, 32'h1,        32'h0,        4'd7},  // R7 old one gone
    {2'd0, 3'd0, 4'd10, 32'h0,        32'h0,        4'd7},  // R7
    {2'd0, 3'd5, 4'd5,  32'h0,        32'h1,        4'd7},  // R7
    {2'd1, 3'd3, 4'd5,  32'h0,        32'h1,        4'd5},  // R5 no write
    {2'd0, 3'd6, 4'd5,  32'h0,        32'h1,        4'd10}, // R10 survives
    {2'd0, 3'd0, 4'd5,  32'h0,        32'h0,        4'd10}, // R10
    {2'd2, 3'd7, 4'd3,  32'h99,       32'h77,       4'd3},  // R3 code 7
    {2'd0, 3'd0, 4'd3,  32'h0,        32'h77,       4'd3}   // R3
  };

  task automatic check(bit ok, int rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic drive(int c, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] wd);
    req_valid[c]         = 1'b1;
    req_op[c*3 +: 3]     = op;
    req_addr[c*AW +: AW] = a;
    req_wdata[c*DW +: DW] = wd;
  endtask

  task automatic do_op(int c, logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] wd,
                       logic [DW-1:0] exp, int rq);
    @(negedge clk);
    drive(c, op, a, wd);
    #1;
    while (!req_ready[c]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[c] = 1'b0;
    check(rsp_valid == 1'b1 && rsp_core == 2'(c), rq, "response core",
          {30'd0, rsp_core}, c);
    check(rsp_data == exp, rq, "response data", rsp_data, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check(rsp_valid == 1'b0, 11, "rsp_valid in reset", {31'd0, rsp_valid}, 0);
    req_valid = '1;
    #1;
    check(req_ready == '0, 11, "req_ready in reset", {28'd0, req_ready}, 0);
    req_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_op(int'(VEC[i][76:75]), VEC[i][74:72], VEC[i][71:68], VEC[i][67:36],
            VEC[i][35:4], int'(VEC[i][3:0]));
    end

    // R2: last core served was 0, so the order is 1,2,3,0
    @(negedge clk);
    for (int c = 0; c < NC; c++) drive(c, 3'd0, 4'd7, 32'h0);
    for (int k = 0; k < NC; k++) begin
      automatic int e = (1 + k) % NC;
      #1;
      check(req_ready == 4'(1 << e), 2, "round-robin grant", {28'd0, req_ready}, 1 << e);
      @(posedge clk);
      @(negedge clk);
      req_valid[e] = 1'b0;
      check(rsp_valid && rsp_core == 2'(e), 2, "round-robin response core",
            {30'd0, rsp_core}, e);
      check(rsp_data == 32'h2, 2, "round-robin data", rsp_data, 32'h2);
    end

    // R1: back-pressure holds the response and blocks new grants
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(1, 3'd0, 4'd7, 32'h0);
    @(posedge clk);
    @(negedge clk);
    req_valid[1] = 1'b0;
    drive(2, 3'd0, 4'd9, 32'h0);
    for (int k = 0; k < 3; k++) begin
      #1;
      check(req_ready == '0, 1, "no grant while stalled", {28'd0, req_ready}, 0);
      check(rsp_valid && rsp_core == 2'd1 && rsp_data == 32'h2, 1, "held response",
            rsp_data, 32'h2);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #1;
    check(req_ready == 4'b0100, 1, "grant after drain", {28'd0, req_ready}, 4'b0100);
    @(posedge clk);
    @(negedge clk);
    req_valid[2] = 1'b0;
    check(rsp_valid && rsp_core == 2'd2 && rsp_data == 32'h0, 1, "next response",
          {30'd0, rsp_core}, 2);

    // R11: reset clears memory and reservations
    do_op(0, 3'd5, 4'd12, 32'h0, 32'h0, 7);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(rsp_valid == 1'b0, 11, "rsp_valid after reset", {31'd0, rsp_valid}, 0);
    do_op(0, 3'd0, 4'd3, 32'h0, 32'h0, 11);
    do_op(0, 3'd6, 4'd12, 32'h5, 32'h0, 11);
    do_op(1, 3'd0, 4'd12, 32'h0, 32'h0, 11);

    finish_run();
  end

endmodule